// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block holds the coherence rules for one line of a snooping cache. The cache presents the line's current state and a command on one of three independent paths, and one clock later the block answers. The processor path returns the bus command a miss or write must issue. The fill path returns the state to install when a bus transaction completes. The snoop path returns the new state for a line that another agent's bus transaction hits, and says whether this cache must drive the data and whether it must raise the shared wire.

One static parameter selects one of four invalidation protocols: three-state (MSI), with exclusive (MESI), with owned (MOSI), or with both (MOESI). A second parameter selects whether a write to a clean shared copy uses a dedicated upgrade transaction or a full read-for-ownership. A line state is three coherence bits, valid in bit 2, writable in bit 1 and dirty in bit 0. Any wider status bits sit above those three and are carried through the fill and snoop paths untouched. Two saturating counters record how many defined processor lookups and defined snoop lookups have taken place.

Top module: `coh_state_ctrl`

## Requirements
- R1: Coherence states are Invalid=000, Shared=100, Exclusive=110, Owned=101, Modified=111 in bits [2:0]. Fill and snoop results keep bits [STATUS_W-1:3] of the input state unchanged.
- R2: Command codes are Read=0, Write=1, ReadEx=2, Upgrade=3, Invalidate=4, WriteInvalidate=5, SoftPrefetch=6, HardPrefetch=7, and the bus command uses the same codes. On the processor path from Invalid, Read and both prefetch commands issue Read (0), and Write issues ReadEx (2).
- R3: A Write to Shared issues Upgrade (3) when UPGRADES=1 and ReadEx (2) when UPGRADES=0. In MOSI and MOESI, a Write to Owned issues the same command.
- R4: When req_wb is high, the processor path returns bus command 8 (writeback), flags no error and is not counted.
- R5: A Read fill into Invalid installs Shared in MSI and MOSI. In MESI and MOESI it installs Exclusive, or Shared when rsp_shared is high.
- R6: A ReadEx fill into Invalid installs Modified. So does the write-to-shared command of R3 completing on a Shared line, or on an Owned line in MOSI and MOESI.
- R7: On a snooped Read, Modified supplies data and raises shared, going to Shared (MSI, MESI) or Owned (MOSI, MOESI). Owned supplies, raises shared and stays Owned. Exclusive raises shared and goes to Shared. Shared raises shared, except in MSI, and stays Shared. Invalid is unchanged.
- R8: On a snooped ReadEx, Modified and Owned supply and go Invalid, while Shared and Exclusive go Invalid without supplying. A snooped Upgrade sends Shared and Owned to Invalid and leaves Invalid alone. The Upgrade snoop is defined only when UPGRADES=1 or the protocol has Owned.
- R9: A snooped Invalidate or WriteInvalidate sends every state that the protocol defines to Invalid.
- R10: A snoop with snp_present low or snp_wb high returns the input state unchanged, with no supply, no shared, no error, and is not counted.
- R11: Any state and command pair not defined above for the selected protocol raises the path's error output. The state is returned unchanged, the bus command is 0 and the snoop flags are low. This includes states the protocol does not use.
- R12: cfg_err is high exactly when the protocol has Owned and UPGRADES=0.
- R13: req_count and snp_count clear on reset, count each defined processor lookup and each defined present, non-writeback snoop, and hold at all ones.
- R14: Every result and its out_valid appear on the clock after the input valid. out_valid is low in the cycle after an idle input, and all outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor lookup strobe |
| req_cmd | input | 3 | Processor command |
| req_wb | input | 1 | Writeback, bypasses the table |
| req_coh | input | 3 | Current coherence bits |
| rsp_valid | input | 1 | Fill lookup strobe |
| rsp_cmd | input | 3 | Completed bus command |
| rsp_shared | input | 1 | Shared wire seen with the fill |
| rsp_state | input | STATUS_W | Full current line status |
| snp_valid | input | 1 | Snoop lookup strobe |
| snp_cmd | input | 3 | Snooped bus command |
| snp_present | input | 1 | Line is held in this cache |
| snp_wb | input | 1 | Snooped command is a writeback |
| snp_state | input | STATUS_W | Full current line status |
| req_out_valid | output | 1 | Processor result valid |
| req_bus_cmd | output | 4 | Bus command to issue |
| req_err | output | 1 | Undefined processor lookup |
| rsp_out_valid | output | 1 | Fill result valid |
| rsp_new_state | output | STATUS_W | Status to install |
| rsp_err | output | 1 | Undefined fill lookup |
| snp_out_valid | output | 1 | Snoop result valid |
| snp_new_state | output | STATUS_W | Status after the snoop |
| snp_supply | output | 1 | This cache must drive the data |
| snp_shared | output | 1 | Raise the shared wire |
| snp_err | output | 1 | Undefined snoop lookup |
| req_count | output | CNT_W | Defined processor lookups, saturating |
| snp_count | output | CNT_W | Defined snoop lookups, saturating |
| cfg_err | output | 1 | Illegal parameter combination |

## Verification
A wrong table entry shows up on the cycle after the offending lookup, as a wrong bus command, a wrong installed state, a missing supply or shared flag, or a spurious or missing error. Nothing is hidden in a pipeline. The bench sweeps every state and command pair, including the unused encodings, with both shared-wire values. It does this for all four protocols and both upgrade settings at once, so a single mis-entry is caught on its own cycle. Counter faults accumulate silently, so they appear only when the totals are compared after the sweep. Some totals are saturated and some are not.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int COH_W = 3;
  localparam int P_MSI   = 0;
  localparam int P_MESI  = 1;
  localparam int P_MOSI  = 2;
  localparam int P_MOESI = 3;

  localparam logic [2:0] CMD_RD   = 3'd0;
  localparam logic [2:0] CMD_WR   = 3'd1;
  localparam logic [2:0] CMD_RDX  = 3'd2;
  localparam logic [2:0] CMD_UPG  = 3'd3;
  localparam logic [2:0] CMD_INV  = 3'd4;
  localparam logic [2:0] CMD_WINV = 3'd5;
  localparam logic [2:0] CMD_SPF  = 3'd6;
  localparam logic [2:0] CMD_HPF  = 3'd7;

  localparam logic [3:0] BUS_WBACK = 4'd8;

  // bit2 valid, bit1 writable, bit0 dirty
  localparam logic [2:0] ST_I = 3'b000;
  localparam logic [2:0] ST_S = 3'b100;
  localparam logic [2:0] ST_E = 3'b110;
  localparam logic [2:0] ST_O = 3'b101;
  localparam logic [2:0] ST_M = 3'b111;

  function automatic logic st_known(logic has_o, logic has_e, logic [2:0] s);
    return (s == ST_I) || (s == ST_S) || (s == ST_M) ||
           (has_e && s == ST_E) || (has_o && s == ST_O);
  endfunction
endpackage

// File: rtl/coh_req_map.sv
module coh_req_map import coh_pkg::*; #(
  parameter bit HAS_O = 1'b1,
  parameter bit UPG   = 1'b1
) (
  input  logic [2:0] st,
  input  logic [2:0] cmd,
  output logic [3:0] bus,
  output logic       ok
);
  localparam logic [3:0] WTS = UPG ? {1'b0, CMD_UPG} : {1'b0, CMD_RDX};

  always_comb begin
    bus = 4'd0;
    ok  = 1'b0;
    case (st)
      ST_I: begin
        if (cmd == CMD_RD || cmd == CMD_SPF || cmd == CMD_HPF) begin
          bus = {1'b0, CMD_RD};
          ok  = 1'b1;
        end else if (cmd == CMD_WR) begin
          bus = {1'b0, CMD_RDX};
          ok  = 1'b1;
        end
      end
      ST_S: if (cmd == CMD_WR) begin
        bus = WTS;
        ok  = 1'b1;
      end
      ST_O: if (HAS_O && cmd == CMD_WR) begin
        bus = WTS;
        ok  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_rsp_map.sv
module coh_rsp_map import coh_pkg::*; #(
  parameter bit HAS_O = 1'b1,
  parameter bit HAS_E = 1'b1,
  parameter bit UPG   = 1'b1
) (
  input  logic [2:0] st,
  input  logic [2:0] cmd,
  input  logic       shared,
  output logic [2:0] nst,
  output logic       ok
);
  localparam logic [2:0] WTS = UPG ? CMD_UPG : CMD_RDX;

  always_comb begin
    nst = st;
    ok  = 1'b0;
    if (st == ST_I && cmd == CMD_RD) begin
      nst = (HAS_E && !shared) ? ST_E : ST_S;
      ok  = 1'b1;
    end else if (st == ST_I && cmd == CMD_RDX) begin
      nst = ST_M;
      ok  = 1'b1;
    end else if (cmd == WTS && (st == ST_S || (HAS_O && st == ST_O))) begin
      nst = ST_M;
      ok  = 1'b1;
    end
  end
endmodule

// File: rtl/coh_snp_map.sv
module coh_snp_map import coh_pkg::*; #(
  parameter bit HAS_O = 1'b1,
  parameter bit HAS_E = 1'b1,
  parameter bit UPG   = 1'b1
) (
  input  logic [2:0] st,
  input  logic [2:0] cmd,
  output logic [2:0] nst,
  output logic       supply,
  output logic       shr,
  output logic       ok
);
  localparam bit UPG_SNOOP = UPG || HAS_O;
  localparam bit S_SHR     = HAS_O || HAS_E;

  always_comb begin
    nst    = st;
    supply = 1'b0;
    shr    = 1'b0;
    ok     = 1'b0;
    if (st_known(HAS_O, HAS_E, st)) begin
      if (cmd == CMD_INV || cmd == CMD_WINV) begin
        nst = ST_I;
        ok  = 1'b1;
      end else begin
        case (st)
          ST_I: ok = (cmd == CMD_RD) || (cmd == CMD_RDX) || (UPG_SNOOP && cmd == CMD_UPG);
          ST_S: begin
            if (cmd == CMD_RD) begin
              ok = 1'b1; shr = S_SHR;
            end else if (cmd == CMD_RDX || (UPG_SNOOP && cmd == CMD_UPG)) begin
              ok = 1'b1; nst = ST_I;
            end
          end
          ST_E: begin
            if (cmd == CMD_RD) begin
              ok = 1'b1; shr = 1'b1; nst = ST_S;
            end else if (cmd == CMD_RDX) begin
              ok = 1'b1; nst = ST_I;
            end
          end
          ST_M: begin
            if (cmd == CMD_RD) begin
              ok = 1'b1; supply = 1'b1; shr = 1'b1; nst = HAS_O ? ST_O : ST_S;
            end else if (cmd == CMD_RDX) begin
              ok = 1'b1; supply = 1'b1; nst = ST_I;
            end
          end
          ST_O: begin
            if (cmd == CMD_RD) begin
              ok = 1'b1; supply = 1'b1; shr = 1'b1;
            end else if (cmd == CMD_RDX) begin
              ok = 1'b1; supply = 1'b1; nst = ST_I;
            end else if (cmd == CMD_UPG) begin
              ok = 1'b1; nst = ST_I;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/coh_sat_counter.sv
module coh_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (inc && count != TOP) count <= count + 1'b1;
  end
endmodule

// File: rtl/coh_state_ctrl.sv
module coh_state_ctrl import coh_pkg::*; #(
  parameter int PROTO    = P_MOESI,
  parameter bit UPGRADES = 1'b1,
  parameter int STATUS_W = 4,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_cmd,
  input  logic                req_wb,
  input  logic [2:0]          req_coh,
  input  logic                rsp_valid,
  input  logic [2:0]          rsp_cmd,
  input  logic                rsp_shared,
  input  logic [STATUS_W-1:0] rsp_state,
  input  logic                snp_valid,
  input  logic [2:0]          snp_cmd,
  input  logic                snp_present,
  input  logic                snp_wb,
  input  logic [STATUS_W-1:0] snp_state,
  output logic                req_out_valid,
  output logic [3:0]          req_bus_cmd,
  output logic                req_err,
  output logic                rsp_out_valid,
  output logic [STATUS_W-1:0] rsp_new_state,
  output logic                rsp_err,
  output logic                snp_out_valid,
  output logic [STATUS_W-1:0] snp_new_state,
  output logic                snp_supply,
  output logic                snp_shared,
  output logic                snp_err,
  output logic [CNT_W-1:0]    req_count,
  output logic [CNT_W-1:0]    snp_count,
  output logic                cfg_err
);
  localparam bit HAS_O   = (PROTO == P_MOSI) || (PROTO == P_MOESI);
  localparam bit HAS_E   = (PROTO == P_MESI) || (PROTO == P_MOESI);
  localparam bit CFG_BAD = HAS_O && !UPGRADES;

  logic [3:0] rq_bus;
  logic       rq_ok;
  logic [2:0] rs_nst;
  logic       rs_ok;
  logic [2:0] sn_nst;
  logic       sn_sup, sn_shr, sn_ok;
  logic       sn_bypass;

  coh_req_map #(.HAS_O(HAS_O), .UPG(UPGRADES)) u_req (
    .st(req_coh), .cmd(req_cmd), .bus(rq_bus), .ok(rq_ok));

  coh_rsp_map #(.HAS_O(HAS_O), .HAS_E(HAS_E), .UPG(UPGRADES)) u_rsp (
    .st(rsp_state[COH_W-1:0]), .cmd(rsp_cmd), .shared(rsp_shared),
    .nst(rs_nst), .ok(rs_ok));

  coh_snp_map #(.HAS_O(HAS_O), .HAS_E(HAS_E), .UPG(UPGRADES)) u_snp (
    .st(snp_state[COH_W-1:0]), .cmd(snp_cmd), .nst(sn_nst),
    .supply(sn_sup), .shr(sn_shr), .ok(sn_ok));

  assign sn_bypass = !snp_present || snp_wb;
  assign cfg_err   = CFG_BAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_out_valid <= 1'b0;
      req_bus_cmd   <= '0;
      req_err       <= 1'b0;
    end else begin
      req_out_valid <= req_valid;
      if (req_valid) begin
        req_bus_cmd <= req_wb ? BUS_WBACK : rq_bus;
        req_err     <= !req_wb && !rq_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_out_valid <= 1'b0;
      rsp_new_state <= '0;
      rsp_err       <= 1'b0;
    end else begin
      rsp_out_valid <= rsp_valid;
      if (rsp_valid) begin
        rsp_new_state <= {rsp_state[STATUS_W-1:COH_W], rs_nst};
        rsp_err       <= !rs_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_out_valid <= 1'b0;
      snp_new_state <= '0;
      snp_supply    <= 1'b0;
      snp_shared    <= 1'b0;
      snp_err       <= 1'b0;
    end else begin
      snp_out_valid <= snp_valid;
      if (snp_valid) begin
        snp_new_state <= sn_bypass ? snp_state
                                   : {snp_state[STATUS_W-1:COH_W], sn_nst};
        snp_supply    <= !sn_bypass && sn_sup;
        snp_shared    <= !sn_bypass && sn_shr;
        snp_err       <= !sn_bypass && !sn_ok;
      end
    end
  end

  coh_sat_counter #(.W(CNT_W)) u_req_cnt (
    .clk(clk), .rst(rst), .inc(req_valid && !req_wb && rq_ok), .count(req_count));

  coh_sat_counter #(.W(CNT_W)) u_snp_cnt (
    .clk(clk), .rst(rst), .inc(snp_valid && !sn_bypass && sn_ok), .count(snp_count));
endmodule

// File: rtl/coh_state_ctrl_chk.sv
module coh_state_ctrl_chk #(
  parameter int STATUS_W = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_wb,
  input logic                rsp_valid,
  input logic [STATUS_W-1:0] rsp_state,
  input logic                snp_valid,
  input logic [2:0]          snp_cmd,
  input logic                snp_present,
  input logic                snp_wb,
  input logic [STATUS_W-1:0] snp_state,
  input logic                req_out_valid,
  input logic [3:0]          req_bus_cmd,
  input logic                req_err,
  input logic [STATUS_W-1:0] rsp_new_state,
  input logic                snp_out_valid,
  input logic [STATUS_W-1:0] snp_new_state,
  input logic                snp_supply,
  input logic                snp_shared,
  input logic                snp_err,
  input logic [CNT_W-1:0]    req_count
);
  p_out_follows_r14: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> req_out_valid);
  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !req_out_valid);
  p_upper_kept_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (rsp_new_state[STATUS_W-1:3] == $past(rsp_state[STATUS_W-1:3])));
  p_wback_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_wb) |=> (req_bus_cmd == 4'd8 && !req_err));
  p_supplier_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (snp_out_valid && snp_supply) |-> (!snp_err && !snp_new_state[1]));
  p_inval_r9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_present && !snp_wb && (snp_cmd == 3'd4 || snp_cmd == 3'd5))
      |=> (snp_err || snp_new_state[2:0] == 3'b000));
  p_absent_r10: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && (!snp_present || snp_wb))
      |=> (!snp_err && !snp_supply && !snp_shared && snp_new_state == $past(snp_state)));
  p_saturate_r13: assert property (@(posedge clk) disable iff (rst)
    (req_count == {CNT_W{1'b1}}) |=> (req_count == {CNT_W{1'b1}}));
endmodule

bind coh_state_ctrl coh_state_ctrl_chk #(.STATUS_W(STATUS_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_wb(req_wb),
  .rsp_valid(rsp_valid), .rsp_state(rsp_state),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_present(snp_present),
  .snp_wb(snp_wb), .snp_state(snp_state),
  .req_out_valid(req_out_valid), .req_bus_cmd(req_bus_cmd), .req_err(req_err),
  .rsp_new_state(rsp_new_state), .snp_out_valid(snp_out_valid),
  .snp_new_state(snp_new_state), .snp_supply(snp_supply),
  .snp_shared(snp_shared), .snp_err(snp_err), .req_count(req_count));

// File: tb/coh_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_state_ctrl_tb_top;
  localparam int NK = 6;
  localparam int SW = 5;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic             req_valid = 0, req_wb = 0, rsp_valid = 0, rsp_shared = 0;
  logic             snp_valid = 0, snp_present = 0, snp_wb = 0;
  logic [2:0]       req_cmd = 0, req_coh = 0, rsp_cmd = 0, snp_cmd = 0;
  logic [SW-1:0]    rsp_state = 0, snp_state = 0;

  logic [NK-1:0]          rq_v, rq_e, rs_v, rs_e, sn_v, sn_sup, sn_shr, sn_e, cfg_e;
  logic [NK-1:0][3:0]     rq_bus;
  logic [NK-1:0][SW-1:0]  rs_st, sn_st;
  logic [NK-1:0][CW-1:0]  rq_cnt, sn_cnt;

  for (genvar k = 0; k < NK; k++) begin : g_cfg
    localparam int PP = (k < 4) ? k : ((k == 4) ? 0 : 3);
    localparam bit UU = (k < 4);
    coh_state_ctrl #(.PROTO(PP), .UPGRADES(UU), .STATUS_W(SW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_wb(req_wb), .req_coh(req_coh),
      .rsp_valid(rsp_valid), .rsp_cmd(rsp_cmd), .rsp_shared(rsp_shared), .rsp_state(rsp_state),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_present(snp_present),
      .snp_wb(snp_wb), .snp_state(snp_state),
      .req_out_valid(rq_v[k]), .req_bus_cmd(rq_bus[k]), .req_err(rq_e[k]),
      .rsp_out_valid(rs_v[k]), .rsp_new_state(rs_st[k]), .rsp_err(rs_e[k]),
      .snp_out_valid(sn_v[k]), .snp_new_state(sn_st[k]), .snp_supply(sn_sup[k]),
      .snp_shared(sn_shr[k]), .snp_err(sn_e[k]),
      .req_count(rq_cnt[k]), .snp_count(sn_cnt[k]), .cfg_err(cfg_e[k]));
  end

  function automatic int cfg_proto(int k);
    return (k < 4) ? k : ((k == 4) ? 0 : 3);
  endfunction
  function automatic bit cfg_upg(int k);
    return k < 4;
  endfunction

  // reference model: {err, bus[3:0]}
  function automatic logic [4:0] ref_req(int p, bit u, logic [2:0] s, logic [2:0] c);
    bit has_o = (p >= 2);
    logic [3:0] wts = u ? 4'd3 : 4'd2;
    if (s == 3'b000 && (c == 0 || c == 6 || c == 7)) return {1'b0, 4'd0};
    if (s == 3'b000 && c == 1) return {1'b0, 4'd2};
    if (c == 1 && (s == 3'b100 || (has_o && s == 3'b101))) return {1'b0, wts};
    return {1'b1, 4'd0};
  endfunction

  // {err, nst[2:0]}
  function automatic logic [3:0] ref_rsp(int p, bit u, logic [2:0] s, logic [2:0] c, logic sh);
    bit has_o = (p >= 2);
    bit has_e = (p == 1 || p == 3);
    logic [2:0] wts = u ? 3'd3 : 3'd2;
    if (s == 3'b000 && c == 0) return {1'b0, (has_e && !sh) ? 3'b110 : 3'b100};
    if (s == 3'b000 && c == 2) return {1'b0, 3'b111};
    if (c == wts && (s == 3'b100 || (has_o && s == 3'b101))) return {1'b0, 3'b111};
    return {1'b1, s};
  endfunction

  // {err, sup, shr, nst[2:0]}
  function automatic logic [5:0] ref_snp(int p, bit u, logic [2:0] s, logic [2:0] c);
    bit has_o = (p >= 2);
    bit has_e = (p == 1 || p == 3);
    bit legal = (s == 3'b000) || (s == 3'b100) || (s == 3'b111) ||
                (has_e && s == 3'b110) || (has_o && s == 3'b101);
    if (!legal) return {3'b100, s};
    if (c == 4 || c == 5) return {3'b000, 3'b000};
    if (c == 0) begin
      case (s)
        3'b000: return {3'b000, s};
        3'b100: return {1'b0, 1'b0, (p != 0), s};
        3'b110: return {3'b001, 3'b100};
        3'b111: return {3'b011, has_o ? 3'b101 : 3'b100};
        default: return {3'b011, 3'b101};
      endcase
    end
    if (c == 2) begin
      if (s == 3'b000) return {3'b000, s};
      if (s == 3'b111 || s == 3'b101) return {3'b010, 3'b000};
      return {3'b000, 3'b000};
    end
    if (c == 3) begin
      if (s == 3'b000 && (u || has_o)) return {3'b000, s};
      if (s == 3'b100 && (u || has_o)) return {3'b000, 3'b000};
      if (s == 3'b101) return {3'b000, 3'b000};
    end
    return {3'b100, s};
  endfunction

  typedef struct packed {
    logic [SW-1:0]          st;
    logic [2:0]             cmd;
    logic                   rwb;
    logic                   bypass;
    logic [NK-1:0][4:0]     e_rq;
    logic [NK-1:0][SW:0]    e_rs;
    logic [NK-1:0][SW+2:0]  e_sn;
  } item_t;

  item_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int exp_rq_n[NK];
  int exp_sn_n[NK];
  bit done = 0;

  task automatic check(bit ok, string tag, string what, int k, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s cfg%0d actual=%0h expected=%0h", tag, what, k, act, exp);
    end
  endtask

  task automatic drive(logic [SW-1:0] st, logic [2:0] c, logic sh, logic pres, logic rwb, logic swb);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_coh = st[2:0]; req_wb = rwb;
    rsp_valid = 1; rsp_cmd = c; rsp_state = st; rsp_shared = sh;
    snp_valid = 1; snp_cmd = c; snp_state = st; snp_present = pres; snp_wb = swb;
    it.st = st; it.cmd = c; it.rwb = rwb; it.bypass = !pres || swb;
    for (int k = 0; k < NK; k++) begin
      logic [4:0] rq;
      logic [3:0] rs;
      logic [5:0] sn;
      rq = rwb ? 5'b0_1000 : ref_req(cfg_proto(k), cfg_upg(k), st[2:0], c);
      rs = ref_rsp(cfg_proto(k), cfg_upg(k), st[2:0], c, sh);
      sn = ref_snp(cfg_proto(k), cfg_upg(k), st[2:0], c);
      it.e_rq[k] = rq;
      it.e_rs[k] = {rs[3], st[SW-1:3], rs[2:0]};
      if (it.bypass) it.e_sn[k] = {3'b000, st};
      else           it.e_sn[k] = {sn[5:3], st[SW-1:3], sn[2:0]};
      if (!rwb && !rq[4]) exp_rq_n[k]++;
      if (!it.bypass && !sn[5]) exp_sn_n[k]++;
    end
    exp_q.push_back(it);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rq_v[0]) begin
      if (exp_q.size() == 0) begin
        check(0, "R14", "unexpected result", 0, 1, 0);
      end else begin
        item_t it;
        string tq, ts, tn;
        it = exp_q.pop_front();
        tq = it.rwb ? "R4" : (it.e_rq[0][4] ? "R11" : ((it.cmd == 1 && it.st[2:0] != 0) ? "R3" : "R2"));
        ts = it.e_rs[3][SW] ? "R11" : ((it.cmd == 0) ? "R5" : "R6");
        tn = it.bypass ? "R10" : (it.cmd == 0 ? "R7" : (it.cmd >= 4 ? "R9" : "R8"));
        for (int k = 0; k < NK; k++) begin
          check(rq_v[k] && rs_v[k] && sn_v[k], "R14", "valid", k, {rq_v[k], rs_v[k], sn_v[k]}, 3'b111);
          check({rq_e[k], rq_bus[k]} == it.e_rq[k], tq, "req", k, {rq_e[k], rq_bus[k]}, it.e_rq[k]);
          check({rs_e[k], rs_st[k]} == it.e_rs[k],
                it.e_rs[k][SW] ? "R11" : ts, "rsp", k, {rs_e[k], rs_st[k]}, it.e_rs[k]);
          check({sn_e[k], sn_sup[k], sn_shr[k], sn_st[k]} == it.e_sn[k],
                it.e_sn[k][SW+2] ? "R11" : tn, "snp", k,
                {sn_e[k], sn_sup[k], sn_shr[k], sn_st[k]}, it.e_sn[k]);
          check(sn_st[k][SW-1:3] == it.st[SW-1:3], "R1", "upper bits", k,
                sn_st[k][SW-1:3], it.st[SW-1:3]);
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < NK; k++) begin exp_rq_n[k] = 0; exp_sn_n[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int k = 0; k < NK; k++) begin
      check({rq_v[k], rs_v[k], sn_v[k], rq_bus[k], rs_st[k], sn_st[k], rq_cnt[k], sn_cnt[k]} == '0,
            "R14", "reset state", k, {rq_cnt[k], sn_cnt[k]}, 0);
      check(cfg_e[k] == (k == 5), "R12", "cfg_err", k, cfg_e[k], (k == 5));
    end
    // full table sweep, upper status bits vary
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 8; c++)
        for (int sh = 0; sh < 2; sh++)
          drive({2'(s + c + sh), 3'(s)}, 3'(c), 1'(sh), 1'b1, 1'b0, 1'b0);
    // absent line, request writeback
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 8; c += 3)
        drive({2'(s), 3'(s)}, 3'(c), 1'b0, 1'b0, 1'b1, 1'b0);
    // snooped writeback on present line
    for (int s = 0; s < 8; s++)
      drive({2'(3 - (s % 4)), 3'(s)}, 3'(s), 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    req_valid = 0; rsp_valid = 0; snp_valid = 0;
    @(negedge clk);
    for (int k = 0; k < NK; k++) begin
      int eq, es;
      eq = (exp_rq_n[k] > 15) ? 15 : exp_rq_n[k];
      es = (exp_sn_n[k] > 15) ? 15 : exp_sn_n[k];
      check(rq_v[k] == 0, "R14", "idle valid", k, rq_v[k], 0);
      check(rq_cnt[k] == 4'(eq), "R13", "req_count", k, rq_cnt[k], eq);
      check(sn_cnt[k] == 4'(es), "R13", "snp_count", k, sn_cnt[k], es);
    end
    check(exp_q.size() == 0, "R14", "leftover items", 0, exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R14 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule